// File: doc/BRIEF.md
# I2C Target Address Match and Transmit Request Logic

This block sits beside the shift engine of an I2C target. When the bit-level front end reports that an address byte is complete, the block decides whether the byte selects this device. It compares the byte against two programmable 7-bit device IDs. When enabled, it also compares it against a stored 8-bit alternate value that identifies a master performing a hardware general call. A match produces a one-cycle pulse, plus a separate general-call pulse when the alternate value was the one that hit.

The block also keeps two transmit status flags for the CPU. The transmit request flag has two modes. In the plain mode it mirrors the transmit FIFO empty condition. In the early mode it fires at most once per transfer, when a matched address arrives with the read direction bit set. The underflow flag is sticky and records a master read that needed data while the FIFO was empty. A status read clears both sticky flags. If a status read and a new set condition land in the same cycle, the set wins.

All inputs are single-cycle strobes or plain levels from an already synchronised front end, on one system clock. There is no data stream at the edge of this block, so it has no valid/ready handshake and no back-pressure. The FIFO, the shifting and the ACK driving live elsewhere.

Top module: `i2c_tgt_addr_txreq`

## Requirements
- R1: After reset `tx_req` is 1 and `tx_underflow`, `addr_match` and `gc_match` are 0.
- R2: An address byte matches when its bits [7:1] equal bits [7:1] of `dev_id_a` or `dev_id_b`. Bit 0 of the byte and of each ID (the direction bit for the byte) does not take part. `addr_match` is high for exactly the one cycle after the `addr_done` cycle.
- R3: When `gc_en` is 1, a byte equal to all 8 bits of `gc_alt_id` matches, and `gc_match` pulses together with `addr_match`. When `gc_en` is 0, the alternate value never matches and `gc_match` stays 0.
- R4: A byte that matches nothing gives no `addr_match` pulse. No pulse appears without `addr_done`.
- R5: With `early_req_en` = 0, `tx_req` equals the `txf_empty` value of the previous cycle, and `stat_rd` has no effect on it.
- R6: With `early_req_en` = 1, `tx_req` becomes 1 in the cycle after an `addr_done` whose byte matched and has bit 0 = 1 (read). A write byte (bit 0 = 0) or a non-matching byte leaves it unchanged.
- R7: In early mode the request fires at most once per transfer. It rearms only on `start_det` (START or repeated START); `stop_det` does not rearm it.
- R8: In early mode `stat_rd` clears `tx_req` in the next cycle. A set in the same cycle as `stat_rd` wins.
- R9: `tx_underflow` becomes 1 in the cycle after `rd_need` while a read transfer is active and `txf_empty` is 1. It stays set until `stat_rd`, and a set in the same cycle as `stat_rd` wins.
- R10: A read transfer becomes active on a matched read address and ends at `start_det` or `stop_det`. A `rd_need` outside an active read, or with `txf_empty` = 0, leaves `tx_underflow` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_det | input | 1 | One-cycle strobe: START or repeated START seen |
| stop_det | input | 1 | One-cycle strobe: STOP seen |
| addr_done | input | 1 | One-cycle strobe on the SCL rise that clocks in the eighth address bit |
| addr_byte | input | 8 | Received address byte, bit 0 = direction (1 = read) |
| rd_need | input | 1 | One-cycle strobe on the SCL rise where the engine needs a transmit byte |
| txf_empty | input | 1 | Transmit FIFO empty level |
| stat_rd | input | 1 | One-cycle strobe: CPU read of the status register |
| early_req_en | input | 1 | 0 = request mirrors FIFO empty, 1 = once-per-transfer early request |
| gc_en | input | 1 | Enables matching against the alternate general-call value |
| dev_id_a | input | 8 | First device ID, bits [7:1] used |
| dev_id_b | input | 8 | Second device ID, bits [7:1] used |
| gc_alt_id | input | 8 | Alternate value matched in full when `gc_en` is 1 |
| addr_match | output | 1 | One-cycle pulse: address selected this device |
| gc_match | output | 1 | One-cycle pulse: the alternate general-call value matched |
| tx_req | output | 1 | Transmit status / early request flag |
| tx_underflow | output | 1 | Sticky transmit underflow flag |

## Verification
On every cycle the assertions check several things. Match pulses follow an `addr_done`, and a general-call pulse never appears without a match. The plain-mode request tracks the previous FIFO empty level. An early-mode request only rises after an address strobe. The underflow flag holds until a status read. Which byte values match a given configuration can only be shown by the bench's sweep of all 256 address bytes over several ID and alternate settings, with expected results computed arithmetically. The same holds for once-per-transfer rearming on START but not STOP, for set-over-clear collisions, and for the end of a read transfer; directed scenarios cover these.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
  localparam int unsigned ID_CNT = 2;

  typedef enum logic {
    TXS_MIRROR = 1'b0,
    TXS_EARLY  = 1'b1
  } txs_mode_e;

  typedef struct packed {
    logic hit;
    logic gc;
    logic rd;
  } addr_res_t;
endpackage

// File: rtl/i2ct_id_cmp.sv
module i2ct_id_cmp #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] byte_in,
  input  logic [W-1:0] id_in,
  output logic         hit
);
  localparam logic [W-1:0] CMP_MASK = ~W'(1);

  always_comb hit = (((byte_in ^ id_in) & CMP_MASK) == '0);
endmodule

// File: rtl/i2ct_addr_dec.sv
module i2ct_addr_dec
  import i2ct_pkg::*;
#(
  parameter int unsigned W = 8,
  parameter int unsigned N = ID_CNT
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                addr_done,
  input  logic [W-1:0]        addr_byte,
  input  logic [N-1:0][W-1:0] ids,
  input  logic                gc_en,
  input  logic [W-1:0]        alt_id,
  output addr_res_t           now_res,
  output logic                match_q,
  output logic                gc_q
);
  logic [N-1:0] id_hit;
  logic         alt_hit;
  logic         any_hit;

  for (genvar i = 0; i < N; i++) begin : g_id
    i2ct_id_cmp #(.W(W)) u_cmp (
      .byte_in(addr_byte),
      .id_in  (ids[i]),
      .hit    (id_hit[i])
    );
  end

  always_comb begin
    alt_hit     = gc_en && (addr_byte == alt_id);
    any_hit     = (|id_hit) || alt_hit;
    now_res.hit = addr_done && any_hit;
    now_res.gc  = addr_done && alt_hit;
    now_res.rd  = addr_done && any_hit && addr_byte[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= 1'b0;
      gc_q    <= 1'b0;
    end else begin
      match_q <= now_res.hit;
      gc_q    <= now_res.gc;
    end
  end
endmodule

// File: rtl/i2ct_txreq.sv
module i2ct_txreq
  import i2ct_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  txs_mode_e mode,
  input  logic      txf_empty,
  input  logic      rd_now,
  input  logic      start_det,
  input  logic      stat_rd,
  output logic      tx_req
);
  logic armed_q;
  logic fire;

  always_comb fire = (mode == TXS_EARLY) && rd_now && armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b1;
      tx_req  <= 1'b1;
    end else begin
      if (start_det)  armed_q <= 1'b1;
      else if (fire)  armed_q <= 1'b0;

      if (mode == TXS_MIRROR) tx_req <= txf_empty;
      else if (fire)          tx_req <= 1'b1;
      else if (stat_rd)       tx_req <= 1'b0;
    end
  end
endmodule

// File: rtl/i2ct_underflow.sv
module i2ct_underflow (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_now,
  input  logic start_det,
  input  logic stop_det,
  input  logic rd_need,
  input  logic txf_empty,
  input  logic stat_rd,
  output logic tx_underflow
);
  logic rd_active_q;
  logic set_now;

  always_comb set_now = rd_need && rd_active_q && txf_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_active_q  <= 1'b0;
      tx_underflow <= 1'b0;
    end else begin
      if (start_det || stop_det) rd_active_q <= 1'b0;
      else if (rd_now)           rd_active_q <= 1'b1;

      if (set_now)      tx_underflow <= 1'b1;
      else if (stat_rd) tx_underflow <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_tgt_addr_txreq.sv
module i2c_tgt_addr_txreq
  import i2ct_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic       addr_done,
  input  logic [7:0] addr_byte,
  input  logic       rd_need,
  input  logic       txf_empty,
  input  logic       stat_rd,
  input  logic       early_req_en,
  input  logic       gc_en,
  input  logic [7:0] dev_id_a,
  input  logic [7:0] dev_id_b,
  input  logic [7:0] gc_alt_id,
  output logic       addr_match,
  output logic       gc_match,
  output logic       tx_req,
  output logic       tx_underflow
);
  localparam int unsigned AW = 8;

  logic [ID_CNT-1:0][AW-1:0] id_vec;
  addr_res_t                 res_now;
  txs_mode_e                 mode;

  always_comb begin
    id_vec[0] = dev_id_a;
    id_vec[1] = dev_id_b;
    mode      = txs_mode_e'(early_req_en);
  end

  i2ct_addr_dec #(.W(AW), .N(ID_CNT)) u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr_done(addr_done),
    .addr_byte(addr_byte),
    .ids      (id_vec),
    .gc_en    (gc_en),
    .alt_id   (gc_alt_id),
    .now_res  (res_now),
    .match_q  (addr_match),
    .gc_q     (gc_match)
  );

  i2ct_txreq u_req (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .txf_empty(txf_empty),
    .rd_now   (res_now.rd),
    .start_det(start_det),
    .stat_rd  (stat_rd),
    .tx_req   (tx_req)
  );

  i2ct_underflow u_ufl (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_now      (res_now.rd),
    .start_det   (start_det),
    .stop_det    (stop_det),
    .rd_need     (rd_need),
    .txf_empty   (txf_empty),
    .stat_rd     (stat_rd),
    .tx_underflow(tx_underflow)
  );
endmodule

// File: rtl/i2ct_chk.sv
module i2ct_chk (
  input logic clk,
  input logic rst_n,
  input logic addr_done,
  input logic txf_empty,
  input logic stat_rd,
  input logic early_req_en,
  input logic addr_match,
  input logic gc_match,
  input logic tx_req,
  input logic tx_underflow
);
  logic past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R2
  match_after_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && addr_match) |-> $past(addr_done));

  // R3
  gc_implies_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gc_match |-> addr_match);

  // R5
  mirror_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(early_req_en)) |-> (tx_req == $past(txf_empty)));

  // R6
  early_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(early_req_en) && $rose(tx_req)) |-> $past(addr_done));

  // R9
  underflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(tx_underflow) && !$past(stat_rd)) |-> tx_underflow);
endmodule

bind i2c_tgt_addr_txreq i2ct_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .addr_done   (addr_done),
  .txf_empty   (txf_empty),
  .stat_rd     (stat_rd),
  .early_req_en(early_req_en),
  .addr_match  (addr_match),
  .gc_match    (gc_match),
  .tx_req      (tx_req),
  .tx_underflow(tx_underflow)
);

// File: tb/test_i2c_tgt_addr_txreq.sv
`timescale 1ns/1ps
module test_i2c_tgt_addr_txreq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_det = 0, stop_det = 0, addr_done = 0, rd_need = 0;
  logic       txf_empty = 1, stat_rd = 0, early_req_en = 0, gc_en = 0;
  logic [7:0] addr_byte = 0, dev_id_a = 0, dev_id_b = 0, gc_alt_id = 0;
  logic       addr_match, gc_match, tx_req, tx_underflow;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  i2c_tgt_addr_txreq i_i2c_tgt_addr_txreq (
    .clk(clk), .rst_n(rst_n), .start_det(start_det), .stop_det(stop_det),
    .addr_done(addr_done), .addr_byte(addr_byte), .rd_need(rd_need),
    .txf_empty(txf_empty), .stat_rd(stat_rd), .early_req_en(early_req_en),
    .gc_en(gc_en), .dev_id_a(dev_id_a), .dev_id_b(dev_id_b),
    .gc_alt_id(gc_alt_id), .addr_match(addr_match), .gc_match(gc_match),
    .tx_req(tx_req), .tx_underflow(tx_underflow)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  // drive strobes for one cycle, then sample after the edge
  task automatic step(input logic st, input logic sp, input logic ad,
                      input logic [7:0] b, input logic rn, input logic sr);
    start_det = st; stop_det = sp; addr_done = ad; addr_byte = b;
    rd_need = rn; stat_rd = sr;
    @(negedge clk);
    start_det = 0; stop_det = 0; addr_done = 0; rd_need = 0; stat_rd = 0;
  endtask

  task automatic idle();
    step(0, 0, 0, 8'h00, 0, 0);
  endtask

  initial begin
    int unsigned lim = 200000;
    while (cycles < lim) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    $display("FAIL watchdog actual=%0d expected<%0d", cycles, lim);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 tx_req reset", tx_req, 1'b1);
    chk("R1 underflow reset", tx_underflow, 1'b0);
    chk("R1 match reset", addr_match, 1'b0);
    chk("R1 gc reset", gc_match, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5: mirror mode follows txf_empty, stat_rd ignored
    early_req_en = 0;
    for (int k = 0; k < 8; k++) begin
      logic e;
      e = k[0] ^ k[2];
      txf_empty = e;
      step(0, 0, 0, 8'h00, 0, k[1]);
      chk("R5 mirror", tx_req, e);
    end
    txf_empty = 1;

    // R2 R3 R4 R6 R9: sweep all bytes over several configurations
    early_req_en = 1;
    for (int cfg = 0; cfg < 4; cfg++) begin
      dev_id_a  = 8'h10 + 8'(cfg * 34);
      dev_id_b  = 8'hA3 ^ 8'(cfg * 17);
      gc_alt_id = 8'h3C + 8'(cfg * 3);
      gc_en     = cfg[0];
      for (int b = 0; b < 256; b++) begin
        logic [7:0] by;
        logic hit, gch;
        by  = 8'(b);
        gch = gc_en && (by == gc_alt_id);
        hit = (by[7:1] == dev_id_a[7:1]) || (by[7:1] == dev_id_b[7:1]) || gch;
        step(1, 0, 0, 8'h00, 0, 1);
        chk("R8 cleared by read", tx_req, 1'b0);
        step(0, 0, 1, by, 0, 0);
        chk(hit ? "R2 match" : "R4 no match", addr_match, hit);
        chk("R3 gc", gc_match, gch);
        chk("R6 early req", tx_req, hit && by[0]);
        step(0, 0, 0, 8'h00, 1, 0);
        chk("R2 single pulse", addr_match, 1'b0);
        chk("R9 underflow", tx_underflow, hit && by[0]);
        step(0, 1, 0, 8'h00, 0, 1);
      end
    end

    // R7: once per transfer, rearm only at START
    dev_id_a = 8'h42; gc_en = 0;
    step(1, 0, 0, 8'h00, 0, 1);
    step(0, 0, 1, 8'h43, 0, 0);
    chk("R7 first fires", tx_req, 1'b1);
    step(0, 0, 0, 8'h00, 0, 1);
    chk("R8 clear", tx_req, 1'b0);
    step(0, 0, 1, 8'h43, 0, 0);
    chk("R7 no second fire", tx_req, 1'b0);
    step(0, 1, 0, 8'h00, 0, 0);
    step(0, 0, 1, 8'h43, 0, 0);
    chk("R7 stop does not rearm", tx_req, 1'b0);
    step(1, 0, 0, 8'h00, 0, 0);
    step(0, 0, 1, 8'h43, 0, 0);
    chk("R7 start rearms", tx_req, 1'b1);

    // R8: set wins over read
    step(1, 0, 0, 8'h00, 0, 1);
    step(0, 0, 1, 8'h43, 0, 1);
    chk("R8 set wins", tx_req, 1'b1);
    step(0, 0, 0, 8'h00, 0, 0);
    chk("R8 holds", tx_req, 1'b1);

    // R9: set wins, sticky, cleared by read
    step(0, 0, 0, 8'h00, 1, 1);
    chk("R9 set wins", tx_underflow, 1'b1);
    idle(); idle();
    chk("R9 sticky", tx_underflow, 1'b1);
    step(0, 0, 0, 8'h00, 0, 1);
    chk("R9 clear", tx_underflow, 1'b0);

    // R10: not empty, then after stop, then after repeated start
    txf_empty = 0;
    step(0, 0, 0, 8'h00, 1, 0);
    chk("R10 fifo not empty", tx_underflow, 1'b0);
    txf_empty = 1;
    step(0, 1, 0, 8'h00, 0, 0);
    step(0, 0, 0, 8'h00, 1, 0);
    chk("R10 after stop", tx_underflow, 1'b0);
    step(1, 0, 0, 8'h00, 0, 0);
    step(0, 0, 1, 8'h43, 0, 0);
    step(1, 0, 0, 8'h00, 0, 0);
    step(0, 0, 0, 8'h00, 1, 0);
    chk("R10 after repeated start", tx_underflow, 1'b0);
    step(0, 0, 1, 8'h42, 0, 0);
    step(0, 0, 0, 8'h00, 1, 0);
    chk("R10 write transfer", tx_underflow, 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule